// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block lets software run transactions on a single-wire, open-drain bus without timing them itself. Software writes an instruction word into a small 32-bit register bank, sets a start bit and waits for completion, either by polling the status word or by taking a level interrupt. The controller then produces the timed reset/presence window, single-bit slots or eight-slot byte transfers on the bus. It samples the line and returns the result in a data register and in the status word.

The line is never driven high. The block only asserts a drive-low enable, and the line level comes back through a two-flop synchroniser. All slot timing is counted in microsecond ticks from a prescaler on the system clock. The prescaler is restarted at each launch, so every transaction starts exactly on a tick boundary.

Top module: `owire_master`

## Requirements
- R1: After reset the status word reads 0x0000_0010 (ready set, done clear, presence bit clear), the interrupt output is low and the drive-low output is released.
- R2: Offset 0x1C reads 0x10EE4453. Offset 0x18 reads the major version (1) in bits [23:8] and the minor version (0) in bits [7:0].
- R3: Opcode 0x8 in instruction bits [11:8] holds the line low for 480 µs. It samples the line 550 µs after the start and finishes 960 µs after the start. Status bit 31 becomes 1 when the line was high at the sample (no device) and 0 when it was low.
- R4: Opcode 0xF sends instruction bits [7:0] least-significant bit first as eight slots of 70 µs each. A 1 is a 6 µs low pulse and a 0 is a 60 µs low pulse.
- R5: Opcode 0xE sends the value in instruction bit 0 as one slot, with a 6 µs low pulse for a 1 and a 60 µs low pulse for a 0.
- R6: Opcode 0xD runs eight 6 µs read slots and samples the line 15 µs into each slot. The received byte, least-significant bit first, appears in data register (offset 0x10) bits [7:0] with the upper bits zero.
- R7: Opcode 0xC runs one read slot and places the sampled level in data register bit 0, with all other bits zero.
- R8: Writing control (offset 0x4) with bit 0 set launches the instruction. Ready (status bit 4) drops on the next cycle. Done (status bit 0) then stays set until control bit 0 is written 0, after which ready returns and done clears.
- R9: A control write with bit 0 set while a transaction is running or done is pending does not start a second transaction. A new instruction written meanwhile does not alter the running one.
- R10: The interrupt output is high exactly when (enable bit 4 and ready) or (enable bit 0 and done) holds, where the enables are bits of offset 0x8. Writing 0 to the enable register drops the interrupt.
- R11: Writing control bit 31 aborts at once. The line is released, the state returns to ready, done, start bit, data and presence are cleared, and the status word reads 0x0000_0010.
- R12: An instruction whose opcode is not 0x8, 0xC, 0xD, 0xE or 0xF completes on the cycle after launch with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Active-high level interrupt |
| bus_drive_low | output | 1 | 1 pulls the bus line low, 0 releases it |
| bus_line | input | 1 | Sampled bus line level (asynchronous) |

## Verification
A wrong slot counter or bit counter shows up at the drive-low port within one slot, as a low pulse of the wrong width or a wrong number of pulses. The bench measures both to the cycle. A wrong sample point or shift direction only appears when the transaction finishes, as a wrong data or presence value. For that reason the slave model answers read slots with asymmetric byte patterns and drives the presence pulse only inside a bounded window. A stuck handshake state is visible within a cycle in the ready, done and interrupt bits, and the bench checks those bits before completion, while done is held, and after the start bit is cleared.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {SL_IDLE, SL_RESET, SL_SLOT} slot_st_e;
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} phase_e;

  localparam logic [3:0] OP_RST    = 4'h8;
  localparam logic [3:0] OP_RDBIT  = 4'hC;
  localparam logic [3:0] OP_RDBYTE = 4'hD;
  localparam logic [3:0] OP_WRBIT  = 4'hE;
  localparam logic [3:0] OP_WRBYTE = 4'hF;

  localparam logic [4:0] A_INSTR = 5'h00;
  localparam logic [4:0] A_CTRL  = 5'h04;
  localparam logic [4:0] A_IEN   = 5'h08;
  localparam logic [4:0] A_STAT  = 5'h0C;
  localparam logic [4:0] A_DATA  = 5'h10;
  localparam logic [4:0] A_VER   = 5'h18;
  localparam logic [4:0] A_ID    = 5'h1C;

  localparam logic [31:0] ID_WORD = 32'h10EE4453;

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i || cnt_q == LAST) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int RST_LOW_US    = 480,
  parameter int RST_SAMPLE_US = 550,
  parameter int RST_TOTAL_US  = 960,
  parameter int SLOT_US       = 70,
  parameter int W1_LOW_US     = 6,
  parameter int W0_LOW_US     = 60,
  parameter int SAMPLE_US     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_i,
  input  logic       tick_i,
  input  logic       launch_i,
  input  logic       kind_rst_i,
  input  logic       nbits8_i,
  input  logic [7:0] tx_i,
  input  logic       line_i,
  output logic       drive_low_o,
  output logic       busy_o,
  output logic       finish_o,
  output logic [7:0] rx_o,
  output logic       absent_o
);
  localparam int UW = $clog2(RST_TOTAL_US + 1);
  localparam logic [UW-1:0] K_RLOW = UW'(RST_LOW_US);
  localparam logic [UW-1:0] K_RSMP = UW'(RST_SAMPLE_US - 1);
  localparam logic [UW-1:0] K_REND = UW'(RST_TOTAL_US - 1);
  localparam logic [UW-1:0] K_SEND = UW'(SLOT_US - 1);
  localparam logic [UW-1:0] K_SSMP = UW'(SAMPLE_US - 1);
  localparam logic [UW-1:0] K_W1   = UW'(W1_LOW_US);
  localparam logic [UW-1:0] K_W0   = UW'(W0_LOW_US);

  slot_st_e      state_q, state_d;
  logic [UW-1:0] us_q, us_d;
  logic [2:0]    left_q, left_d;
  logic [7:0]    tx_q, tx_d, rx_q, rx_d;
  logic          absent_q, absent_d, drive_q, drive_d;
  logic          sync1_q, line_s;

  // two-flop synchroniser for the open-drain line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      line_s  <= 1'b1;
    end else begin
      sync1_q <= line_i;
      line_s  <= sync1_q;
    end
  end

  always_comb begin
    state_d  = state_q;
    us_d     = us_q;
    left_d   = left_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    absent_d = absent_q;
    finish_o = 1'b0;
    if (abort_i) begin
      state_d  = SL_IDLE;
      us_d     = '0;
      rx_d     = '0;
      absent_d = 1'b0;
    end else begin
      case (state_q)
        SL_IDLE: if (launch_i) begin
          state_d = kind_rst_i ? SL_RESET : SL_SLOT;
          us_d    = '0;
          tx_d    = tx_i;
          left_d  = nbits8_i ? 3'd7 : 3'd0;
        end
        SL_RESET: if (tick_i) begin
          if (us_q == K_RSMP) absent_d = line_s;
          if (us_q == K_REND) begin
            state_d  = SL_IDLE;
            us_d     = '0;
            finish_o = 1'b1;
          end else us_d = us_q + 1'b1;
        end
        SL_SLOT: if (tick_i) begin
          if (us_q == K_SSMP) rx_d = {line_s, rx_q[7:1]};
          if (us_q == K_SEND) begin
            us_d = '0;
            if (left_q == 3'd0) begin
              state_d  = SL_IDLE;
              finish_o = 1'b1;
            end else begin
              left_d = left_q - 1'b1;
              tx_d   = {1'b1, tx_q[7:1]};
            end
          end else us_d = us_q + 1'b1;
        end
        default: state_d = SL_IDLE;
      endcase
    end
    drive_d = ((state_d == SL_RESET) && (us_d < K_RLOW)) ||
              ((state_d == SL_SLOT) && (us_d < (tx_d[0] ? K_W1 : K_W0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SL_IDLE;
      us_q     <= '0;
      left_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      absent_q <= 1'b0;
      drive_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      us_q     <= us_d;
      left_q   <= left_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      absent_q <= absent_d;
      drive_q  <= drive_d;
    end
  end

  assign drive_low_o = drive_q;
  assign busy_o      = (state_q != SL_IDLE);
  assign rx_o        = rx_q;
  assign absent_o    = absent_q;

  // R3
  tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |-> tick_i);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_IDLE) |-> !drive_low_o);
endmodule

// File: rtl/owm_regs.sv
module owm_regs
  import owm_pkg::*;
#(
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        eng_finish_i,
  input  logic [7:0]  eng_rx_i,
  input  logic        eng_absent_i,
  output logic        launch_o,
  output logic        kind_rst_o,
  output logic        nbits8_o,
  output logic [7:0]  tx_o,
  output logic        abort_o,
  output logic        irq_o
);
  localparam logic [31:0] VER_WORD = {8'h00, 16'(VER_MAJOR), 8'(VER_MINOR)};

  phase_e      phase_q, phase_d;
  logic [11:0] instr_q, instr_d;
  logic [3:0]  op_q, op_d;
  logic        go_q, go_d;
  logic [1:0]  ien_q, ien_d;
  logic [31:0] data_q, data_d;
  logic        ctrl_wr, go_req, op_ok, ready, done;
  logic [3:0]  op_cur;

  assign op_cur  = instr_q[11:8];
  assign ctrl_wr = wr_i && (addr_i == A_CTRL);
  assign go_req  = ctrl_wr && wdata_i[0] && !wdata_i[31];
  assign abort_o = ctrl_wr && wdata_i[31];
  assign ready   = (phase_q == PH_IDLE);
  assign done    = (phase_q == PH_FIN);

  always_comb begin
    case (op_cur)
      OP_RST, OP_RDBIT, OP_RDBYTE, OP_WRBIT, OP_WRBYTE: op_ok = 1'b1;
      default:                                          op_ok = 1'b0;
    endcase
    kind_rst_o = (op_cur == OP_RST);
    nbits8_o   = (op_cur == OP_RDBYTE) || (op_cur == OP_WRBYTE);
    case (op_cur)
      OP_WRBIT:  tx_o = {7'h7F, instr_q[0]};
      OP_WRBYTE: tx_o = instr_q[7:0];
      default:   tx_o = 8'hFF;
    endcase
  end

  assign launch_o = go_req && ready && op_ok;

  always_comb begin
    phase_d = phase_q;
    instr_d = instr_q;
    op_d    = op_q;
    go_d    = go_q;
    ien_d   = ien_q;
    data_d  = data_q;
    if (wr_i && addr_i == A_INSTR) instr_d = wdata_i[11:0];
    if (wr_i && addr_i == A_IEN)   ien_d   = {wdata_i[4], wdata_i[0]};
    if (ctrl_wr)                   go_d    = wdata_i[0] && !wdata_i[31];
    if (abort_o) begin
      phase_d = PH_IDLE;
      data_d  = '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (go_req) begin
          phase_d = op_ok ? PH_RUN : PH_FIN;
          op_d    = op_cur;
        end
        PH_RUN: if (eng_finish_i) begin
          phase_d = PH_FIN;
          if (op_q == OP_RDBYTE)     data_d = {24'h0, eng_rx_i};
          else if (op_q == OP_RDBIT) data_d = {31'h0, eng_rx_i[7]};
        end
        PH_FIN: if (!go_d) phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      instr_q <= '0;
      op_q    <= '0;
      go_q    <= 1'b0;
      ien_q   <= '0;
      data_q  <= '0;
    end else begin
      phase_q <= phase_d;
      instr_q <= instr_d;
      op_q    <= op_d;
      go_q    <= go_d;
      ien_q   <= ien_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_INSTR: rdata_o = {20'h0, instr_q};
      A_CTRL:  rdata_o = {31'h0, go_q};
      A_IEN:   rdata_o = {27'h0, ien_q[1], 3'b000, ien_q[0]};
      A_STAT:  rdata_o = {eng_absent_i, 26'h0, ready, 3'b000, done};
      A_DATA:  rdata_o = data_q;
      A_VER:   rdata_o = VER_WORD;
      A_ID:    rdata_o = ID_WORD;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = (ien_q[1] && ready) || (ien_q[0] && done);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_wr) |=> done);
  // R11
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (ready && !done && !go_q));
  // R12
  null_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && ready && !op_ok) |=> done);
endmodule

// File: rtl/owire_master.sv
module owire_master
  import owm_pkg::*;
#(
  parameter int CLK_PER_US    = 50,
  parameter int VER_MAJOR     = 1,
  parameter int VER_MINOR     = 0,
  parameter int RST_LOW_US    = 480,
  parameter int RST_SAMPLE_US = 550,
  parameter int RST_TOTAL_US  = 960,
  parameter int SLOT_US       = 70,
  parameter int W1_LOW_US     = 6,
  parameter int W0_LOW_US     = 60,
  parameter int SAMPLE_US     = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        bus_drive_low,
  input  logic        bus_line
);
  logic       tick, launch, abort, kind_rst, nbits8;
  logic       eng_busy, eng_finish, eng_absent;
  logic [7:0] tx_byte, rx_byte;

  owm_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(launch || abort), .tick_o(tick)
  );

  owm_engine #(
    .RST_LOW_US(RST_LOW_US), .RST_SAMPLE_US(RST_SAMPLE_US),
    .RST_TOTAL_US(RST_TOTAL_US), .SLOT_US(SLOT_US),
    .W1_LOW_US(W1_LOW_US), .W0_LOW_US(W0_LOW_US), .SAMPLE_US(SAMPLE_US)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .abort_i(abort), .tick_i(tick),
    .launch_i(launch), .kind_rst_i(kind_rst), .nbits8_i(nbits8),
    .tx_i(tx_byte), .line_i(bus_line), .drive_low_o(bus_drive_low),
    .busy_o(eng_busy), .finish_o(eng_finish), .rx_o(rx_byte),
    .absent_o(eng_absent)
  );

  owm_regs #(.VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .eng_finish_i(eng_finish),
    .eng_rx_i(rx_byte), .eng_absent_i(eng_absent), .launch_o(launch),
    .kind_rst_o(kind_rst), .nbits8_o(nbits8), .tx_o(tx_byte),
    .abort_o(abort), .irq_o(irq)
  );

  // R9
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !launch);
endmodule

// File: tb/owire_master_tb.sv
module owire_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;
  localparam logic [4:0] A_INSTR = 5'h00, A_CTRL = 5'h04, A_IEN = 5'h08,
                         A_STAT = 5'h0C, A_DATA = 5'h10, A_VER = 5'h18, A_ID = 5'h1C;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [4:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq, bus_drive_low, bus_line, slave_pull;

  always #(CLK_PERIOD / 2) clk = ~clk;

  owire_master #(.CLK_PER_US(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_drive_low(bus_drive_low), .bus_line(bus_line)
  );

  // slave model and pulse recorder
  int mode, dev_present, rd_base;
  logic [7:0] slave_byte;
  int npulse, low_cnt, pull_cnt, since_rel;
  int widths [128];
  logic drv_prev;

  assign slave_pull = (pull_cnt != 0) ||
    (mode == 1 && dev_present != 0 && since_rel >= 15 * P && since_rel < 240 * P);
  assign bus_line = !bus_drive_low && !slave_pull;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npulse <= 0; low_cnt <= 0; pull_cnt <= 0; since_rel <= 1000000; drv_prev <= 1'b0;
    end else begin
      drv_prev <= bus_drive_low;
      if (pull_cnt != 0) pull_cnt <= pull_cnt - 1;
      if (since_rel < 1000000) since_rel <= since_rel + 1;
      if (bus_drive_low) begin
        low_cnt <= low_cnt + 1;
        if (!drv_prev && mode == 2 && slave_byte[(npulse - rd_base) & 7] == 1'b0)
          pull_cnt <= 30 * P;
      end else if (drv_prev) begin
        widths[npulse % 128] <= low_cnt;
        npulse <= npulse + 1;
        low_cnt <= 0;
        since_rel <= 0;
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] s;
    cyc = 0;
    do begin
      rd(A_STAT, s);
      cyc++;
    end while (!s[0] && cyc < 20000);
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    rd(A_STAT, d);
    chk(d == 32'h10, "R1 status after reset", d, 32'h10);
    chk(irq == 1'b0 && bus_drive_low == 1'b0, "R1 irq/drive released", {irq, bus_drive_low}, 0);
    rd(A_ID, d);
    chk(d == 32'h10EE4453, "R2 id word", d, 32'h10EE4453);
    rd(A_VER, d);
    chk(d == 32'h100, "R2 version word", d, 32'h100);
  endtask

  task automatic t_presence(input int present);
    logic [31:0] d;
    int cyc, base;
    mode = 1; dev_present = present; base = npulse;
    wr(A_INSTR, 32'h0800);
    wr(A_CTRL, 32'h1);
    wait_done(cyc);
    chk(cyc >= 960 * P - 2 && cyc <= 960 * P + 2, "R3 reset window length", cyc, 960 * P);
    chk(npulse - base == 1 && widths[base % 128] == 480 * P, "R3 reset low width",
        widths[base % 128], 480 * P);
    rd(A_STAT, d);
    chk(d[31] == (present == 0), "R3 presence bit", d[31], present == 0);
    wr(A_CTRL, 32'h0);
    mode = 0;
  endtask

  task automatic t_write_byte(input logic [7:0] v);
    int cyc, base;
    base = npulse;
    wr(A_INSTR, 32'h0F00 | v);
    wr(A_CTRL, 32'h1);
    wait_done(cyc);
    chk(npulse - base == 8, "R4 slot count", npulse - base, 8);
    for (int i = 0; i < 8; i++)
      chk(widths[(base + i) % 128] == (v[i] ? 6 * P : 60 * P), "R4 slot width lsb-first",
          widths[(base + i) % 128], v[i] ? 6 * P : 60 * P);
    chk(cyc >= 560 * P - 2 && cyc <= 560 * P + 2, "R4 byte duration", cyc, 560 * P);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_write_bit(input logic b);
    int cyc, base;
    base = npulse;
    wr(A_INSTR, 32'h0E00 | b);
    wr(A_CTRL, 32'h1);
    wait_done(cyc);
    chk(npulse - base == 1 && widths[base % 128] == (b ? 6 * P : 60 * P), "R5 bit slot width",
        widths[base % 128], b ? 6 * P : 60 * P);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_read_byte(input logic [7:0] v);
    logic [31:0] d;
    int cyc;
    mode = 2; slave_byte = v; rd_base = npulse;
    wr(A_INSTR, 32'h0D00);
    wr(A_CTRL, 32'h1);
    wait_done(cyc);
    rd(A_DATA, d);
    chk(d == {24'h0, v}, "R6 read byte data", d, v);
    chk(widths[rd_base % 128] == 6 * P, "R6 read slot width", widths[rd_base % 128], 6 * P);
    wr(A_CTRL, 32'h0);
    mode = 0;
  endtask

  task automatic t_read_bit(input logic b);
    logic [31:0] d;
    int cyc;
    mode = 2; slave_byte = {8{b}}; rd_base = npulse;
    wr(A_INSTR, 32'h0C00);
    wr(A_CTRL, 32'h1);
    wait_done(cyc);
    rd(A_DATA, d);
    chk(d == {31'h0, b}, "R7 read bit data", d, b);
    wr(A_CTRL, 32'h0);
    mode = 0;
  endtask

  task automatic t_handshake;
    logic [31:0] d;
    int cyc;
    wr(A_INSTR, 32'h0E01);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, d);
    chk(d[4] == 1'b0 && d[0] == 1'b0, "R8 busy: ready and done low", d, 0);
    wait_done(cyc);
    repeat (20) @(negedge clk);
    rd(A_STAT, d);
    chk(d[4:0] == 5'h01, "R8 done held while go set", d[4:0], 1);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, d);
    chk(d[4:0] == 5'h10, "R8 ready after go cleared", d[4:0], 5'h10);
  endtask

  task automatic t_busy_go;
    int cyc, base;
    logic [31:0] d;
    base = npulse;
    wr(A_INSTR, 32'h0FFF);
    wr(A_CTRL, 32'h1);
    repeat (50) @(negedge clk);
    wr(A_INSTR, 32'h0F00);
    wr(A_CTRL, 32'h1);
    wait_done(cyc);
    wr(A_CTRL, 32'h1);
    repeat (100) @(negedge clk);
    rd(A_STAT, d);
    chk(d[4:0] == 5'h01, "R9 go during done ignored", d[4:0], 1);
    chk(npulse - base == 8, "R9 single transaction", npulse - base, 8);
    chk(widths[(base + 3) % 128] == 6 * P, "R9 running payload kept",
        widths[(base + 3) % 128], 6 * P);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_irq;
    int cyc;
    wr(A_IEN, 32'h1);
    wr(A_INSTR, 32'h0E01);
    wr(A_CTRL, 32'h1);
    repeat (5) @(negedge clk);
    chk(irq == 1'b0, "R10 no irq while running", irq, 0);
    wait_done(cyc);
    chk(irq == 1'b1, "R10 done irq", irq, 1);
    wr(A_IEN, 32'h0);
    chk(irq == 1'b0, "R10 irq dropped by enable clear", irq, 0);
    wr(A_CTRL, 32'h0);
    wr(A_IEN, 32'h10);
    chk(irq == 1'b1, "R10 ready irq", irq, 1);
    wr(A_IEN, 32'h0);
    chk(irq == 1'b0, "R10 ready irq cleared", irq, 0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d;
    t_presence(0);
    wr(A_INSTR, 32'h0800);
    wr(A_CTRL, 32'h1);
    repeat (100) @(negedge clk);
    chk(bus_drive_low == 1'b1, "R11 line low before abort", bus_drive_low, 1);
    wr(A_CTRL, 32'h8000_0000);
    chk(bus_drive_low == 1'b0, "R11 line released", bus_drive_low, 0);
    rd(A_STAT, d);
    chk(d == 32'h10, "R11 status after abort", d, 32'h10);
    rd(A_CTRL, d);
    chk(d == 32'h0, "R11 go cleared", d, 0);
  endtask

  task automatic t_null_op;
    logic [31:0] d;
    int base;
    base = npulse;
    wr(A_INSTR, 32'h0300);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, d);
    chk(d[4:0] == 5'h01, "R12 unknown opcode done at once", d[4:0], 1);
    repeat (20 * P) @(negedge clk);
    chk(npulse == base && bus_drive_low == 1'b0, "R12 no bus activity", npulse - base, 0);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    mode = 0; dev_present = 0; rd_base = 0; slave_byte = 8'h00;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_presence(1);
    t_presence(0);
    t_write_byte(8'hA5);
    t_write_byte(8'h3C);
    t_write_bit(1'b1);
    t_write_bit(1'b0);
    t_read_byte(8'h5C);
    t_read_byte(8'h81);
    t_read_bit(1'b0);
    t_read_bit(1'b1);
    t_handshake();
    t_busy_go();
    t_irq();
    t_soft_reset();
    t_null_op();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule